// File: doc/BRIEF.md
# Host Command Mailbox Controller

This block sits between a host processor and an expansion board. It holds a small set of 16-bit mailbox registers: a command word, a result offset, a low and a high parameter half, and a status word. The host loads a command and its arguments, then writes the status word to signal the board. The block then decodes the command and may answer by rewriting the mailbox in place and raising a level interrupt toward the host.

The command word carries a two-bit group, a four-bit opcode and an eight-bit channel index. Only the system group is handled. Its startup opcode loads a fixed set of base-address values and arms a free-running poll timer. Every other group gets a failure answer. The remaining system opcodes are replies coming back from the host, so the block leaves them alone.

The status word is also the acknowledge path. Writing it with the acknowledge bit set clears the pending interrupt. While the interrupt is pending, the status read-back shows that bit cleared. Once the poll timer is armed, it raises the interrupt again at every expiry unless the interrupt is still pending.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-high reset, all five mailbox registers read 0x0000, `host_irq` is low and the poll timer is disarmed.
- R2: Register select encoding is 0 = command, 1 = offset, 2 = parameter-low, 3 = parameter-high, 4 = status. A write to select 0..3 stores `wdata`, and a read returns the last stored value. Selects 5..7 read 0x0000, and writes to them change nothing.
- R3: A status read returns the stored status word with bit 8 forced to 0 while the interrupt is pending. Otherwise bit 8 reads as stored.
- R4: A status write with bit 8 = 1 clears a pending interrupt. A status write with bit 8 = 0 leaves it pending.
- R5: A status write with bit 0 = 0 starts processing of the stored command. With bit 0 = 1, no processing takes place.
- R6: If the command group (bits 14:13) is not 0, processing writes a failure answer. The command becomes ((command AND 0x7E00) + 0x0400) OR 0x00FF. The offset becomes 0x0000 and both parameter halves become 0xFFFF. The interrupt is raised in the same cycle.
- R7: Group 0, opcode 0xF (bits 12:9) is startup. It loads command 0x8600, offset 0x0000, parameter-low 0x0000 and parameter-high 0x0C00, raises the interrupt and (re)arms the poll timer.
- R8: Any other group-0 opcode leaves all mailbox registers unchanged and raises no interrupt.
- R9: Once armed, the poll timer expires every POLL_PERIOD cycles, counted from the arming write. At an expiry, a non-pending interrupt is raised and a pending one is left as it is.
- R10: When one status write both acknowledges (bit 8 = 1) and triggers a raising command (bit 0 = 0), the interrupt is pending afterwards.
- R11: With `rd_en` low, `rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read enable for the combinational read path |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| host_irq | output | 1 | Level interrupt toward the host, high while pending |

## Verification
Several properties are checked on every cycle:
- Bit 8 of a status read is clear whenever the interrupt is pending.
- A status write with bit 0 set never alters the command word.
- An acknowledge without a trigger drops the interrupt.
- A failure answer leaves the interrupt high with the low code byte at 0xFF.
- A rising interrupt always traces back to a trigger write or a timer expiry.

Other behaviour needs the bench's scenarios. The bench sweeps the full group and opcode space to show the exact rewritten words and that ignored opcodes leave the mailbox untouched. It also shows the exact expiry cycles of the poll timer over several periods, and that an expiry is skipped while the interrupt is still pending.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W = 16;
    localparam int SEL_W  = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 3'd0,
        SEL_OFFS = 3'd1,
        SEL_PLO  = 3'd2,
        SEL_PHI  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    // command word layout
    localparam int GRP_LSB = 13;
    localparam int GRP_W   = 2;
    localparam int OP_LSB  = 9;
    localparam int OP_W    = 4;

    // status word control bits
    localparam int ACK_BIT  = 8;
    localparam int GO_N_BIT = 0;

    typedef enum logic [GRP_W-1:0] {
        GRP_SYSTEM = 2'd0,
        GRP_NET    = 2'd1,
        GRP_RSV2   = 2'd2,
        GRP_RSV3   = 2'd3
    } grp_e;

    localparam logic [OP_W-1:0] OP_STARTUP = 4'hF;

    // answer formatting constants
    localparam word_t KEEP_MASK = 16'h7E00;
    localparam word_t SEQ_STEP  = 16'h0400;
    localparam word_t CODE_FAIL = 16'h00FF;
    localparam word_t CODE_OK   = 16'h0004;
    localparam word_t FAIL_PARM = 16'hFFFF;

    // startup image
    localparam word_t BOOT_CMD  = 16'h8600;
    localparam word_t BOOT_OFFS = 16'h0000;
    localparam word_t BOOT_PLO  = 16'h0000;
    localparam word_t BOOT_PHI  = 16'h0C00;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_FAIL    = 2'd1,
        ACT_STARTUP = 2'd2
    } action_e;

    typedef struct packed {
        word_t cmd;
        word_t offs;
        word_t plo;
        word_t phi;
    } mbox_regs_t;

    function automatic grp_e cmd_group(input word_t c);
        return grp_e'(c[GRP_LSB +: GRP_W]);
    endfunction

    function automatic logic [OP_W-1:0] cmd_opcode(input word_t c);
        return c[OP_LSB +: OP_W];
    endfunction

    function automatic word_t answer_cmd(input word_t c, input logic failed);
        word_t base;
        base = (c & KEEP_MASK) + SEQ_STEP;
        return base | (failed ? CODE_FAIL : CODE_OK);
    endfunction

    function automatic mbox_regs_t fail_frame(input word_t c);
        mbox_regs_t f;
        f.cmd  = answer_cmd(c, 1'b1);
        f.offs = '0;
        f.plo  = FAIL_PARM;
        f.phi  = FAIL_PARM;
        return f;
    endfunction

    function automatic mbox_regs_t boot_frame();
        mbox_regs_t f;
        f.cmd  = BOOT_CMD;
        f.offs = BOOT_OFFS;
        f.plo  = BOOT_PLO;
        f.phi  = BOOT_PHI;
        return f;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
(
    input  word_t      cmd_word,
    input  logic       go,
    output action_e    action,
    output mbox_regs_t frame,
    output logic       raise,
    output logic       arm_poll
);

    grp_e            grp;
    logic [OP_W-1:0] opc;

    always_comb begin
        grp = cmd_group(cmd_word);
        opc = cmd_opcode(cmd_word);
    end

    always_comb begin
        action = ACT_NONE;
        if (go) begin
            unique case (grp)
                GRP_SYSTEM: action = (opc == OP_STARTUP) ? ACT_STARTUP : ACT_NONE;
                GRP_NET,
                GRP_RSV2,
                GRP_RSV3:   action = ACT_FAIL;
                default:    action = ACT_FAIL;
            endcase
        end
    end

    always_comb begin
        unique case (action)
            ACT_FAIL:    frame = fail_frame(cmd_word);
            ACT_STARTUP: frame = boot_frame();
            default:     frame = '0;
        endcase
        raise    = (action != ACT_NONE);
        arm_poll = (action == ACT_STARTUP);
    end

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int POLL_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expire
);

    localparam int CNT_W = (POLL_PERIOD > 1) ? $clog2(POLL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(POLL_PERIOD - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb expire = armed_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            cnt_q   <= RELOAD;
        end else if (armed_q) begin
            cnt_q <= expire ? RELOAD : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    input  logic raise,
    input  logic poll_expire,
    output logic pending
);

    logic pending_q;
    logic pending_d;

    // acknowledge first, then the answer may set it again
    always_comb begin
        pending_d = pending_q & ~ack;
        if (raise)
            pending_d = 1'b1;
        if (poll_expire && !pending_q)
            pending_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pending_q <= 1'b0;
        else     pending_q <= pending_d;
    end

    always_comb pending = pending_q;

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbox_pkg::*;
#(
    parameter int POLL_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              host_irq
);

    mbox_regs_t regs_q;
    word_t      stat_q;
    word_t      cmd_q;

    logic       stat_wr;
    logic       go;
    logic       ack;
    action_e    action;
    mbox_regs_t frame;
    logic       raise;
    logic       arm_poll;
    logic       poll_expire;
    logic       pending;

    always_comb begin
        stat_wr = wr_en && (sel == SEL_STAT);
        go      = stat_wr && !wdata[GO_N_BIT];
        ack     = stat_wr && wdata[ACK_BIT];
        cmd_q   = regs_q.cmd;
    end

    mbox_decode u_decode (
        .cmd_word (regs_q.cmd),
        .go       (go),
        .action   (action),
        .frame    (frame),
        .raise    (raise),
        .arm_poll (arm_poll)
    );

    mbox_poll_timer #(.POLL_PERIOD(POLL_PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm_poll),
        .expire (poll_expire)
    );

    mbox_irq_flag u_irq (
        .clk         (clk),
        .rst         (rst),
        .ack         (ack),
        .raise       (raise),
        .poll_expire (poll_expire),
        .pending     (pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            stat_q <= '0;
        end else if (action != ACT_NONE) begin
            regs_q <= frame;
            stat_q <= wdata;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CMD:  regs_q.cmd  <= wdata;
                SEL_OFFS: regs_q.offs <= wdata;
                SEL_PLO:  regs_q.plo  <= wdata;
                SEL_PHI:  regs_q.phi  <= wdata;
                SEL_STAT: stat_q      <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CMD:  rdata = regs_q.cmd;
                SEL_OFFS: rdata = regs_q.offs;
                SEL_PLO:  rdata = regs_q.plo;
                SEL_PHI:  rdata = regs_q.phi;
                SEL_STAT: rdata = stat_q & ~(word_t'(pending) << ACK_BIT);
                default:  rdata = '0;
            endcase
        end
    end

    always_comb host_irq = pending;

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic              host_irq,
    input logic [WORD_W-1:0] cmd_q,
    input logic              poll_expire
);

    logic stat_wr;
    logic trig;
    always_comb begin
        stat_wr = wr_en && (sel == SEL_STAT);
        trig    = stat_wr && !wdata[GO_N_BIT];
    end

    AST_STATUS_MASK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_STAT && host_irq) |-> !rdata[ACK_BIT]); // R3

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata[ACK_BIT] && wdata[GO_N_BIT] && host_irq) |=> !host_irq); // R4

    AST_NO_TRIGGER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata[GO_N_BIT]) |=> (cmd_q == $past(cmd_q))); // R5

    AST_FAIL_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (trig && cmd_q[GRP_LSB +: GRP_W] != 2'd0) |=> (host_irq && cmd_q[7:0] == 8'hFF)); // R6

    AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trig && cmd_q[GRP_LSB +: GRP_W] == 2'd0 && cmd_q[OP_LSB +: OP_W] != OP_STARTUP)
        |=> (cmd_q == $past(cmd_q))); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> ($past(trig) || $past(poll_expire))); // R9

endmodule

bind cmd_mailbox mbox_checker u_mbox_checker (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .host_irq    (host_irq),
    .cmd_q       (cmd_q),
    .poll_expire (poll_expire)
);

// File: tb/cmd_mailbox_test.sv
`timescale 1ns/100ps
module cmd_mailbox_test;

    localparam int PERIOD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        host_irq;

    int errors = 0;
    int checks = 0;
    int ccount = 0;
    int last_edge = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) ccount <= ccount + 1;

    cmd_mailbox #(.POLL_PERIOD(PERIOD)) uut (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .host_irq (host_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        last_edge = ccount + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] d);
        sel = s; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edge(input int e);
        while (ccount < e) @(negedge clk);
    endtask

    task automatic irq_is(input string req, input logic exp);
        check(req, {15'b0, host_irq}, {15'b0, exp});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        do_reset();

        // R1: reset state
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check("R1 reset register", v, 16'h0000);
        end
        irq_is("R1 reset irq", 1'b0);

        // R2 / R11: storage, unmapped selects, read gating
        wr(3'd0, 16'h1357); wr(3'd1, 16'h2468); wr(3'd2, 16'hBEEF); wr(3'd3, 16'hCAFE);
        wr(3'd5, 16'hFFFF); wr(3'd6, 16'hAAAA); wr(3'd7, 16'h5555);
        rd(3'd0, v); check("R2 command", v, 16'h1357);
        rd(3'd1, v); check("R2 offset", v, 16'h2468);
        rd(3'd2, v); check("R2 param-low", v, 16'hBEEF);
        rd(3'd3, v); check("R2 param-high", v, 16'hCAFE);
        for (int s = 5; s < 8; s++) begin
            rd(3'(s), v); check("R2 unmapped read", v, 16'h0000);
        end
        irq_is("R2 unmapped write no irq", 1'b0);
        sel = 3'd0; #1; check("R11 rd_en low", rdata, 16'h0000);

        // R5: bit0 = 1 does not process (group 1 would fail)
        wr(3'd0, 16'h2A00);
        wr(3'd4, 16'h0001);
        rd(3'd0, v); check("R5 no trigger command", v, 16'h2A00);
        irq_is("R5 no trigger irq", 1'b0);
        rd(3'd4, v); check("R3 status not pending", v, 16'h0001);

        // R10 + R3: ack and trigger in one write
        wr(3'd4, 16'h0100);
        irq_is("R10 ack+trigger pending", 1'b1);
        rd(3'd4, v); check("R3 status bit8 masked", v, 16'h0000);
        rd(3'd0, v); check("R6 answer command", v, 16'h2EFF);
        // R4: bit8 = 0 keeps pending
        wr(3'd4, 16'h0001);
        irq_is("R4 bit8 zero keeps pending", 1'b1);
        rd(3'd4, v); check("R3 status while pending", v, 16'h0001);
        wr(3'd4, 16'h0101);
        irq_is("R4 ack clears", 1'b0);
        rd(3'd4, v); check("R3 status bit8 shown", v, 16'h0101);

        // R6 / R7 / R8: sweep of group and opcode
        for (int g = 0; g < 4; g++) begin
            for (int o = 0; o < 16; o++) begin
                logic [15:0] c, e_cmd, e_off, e_plo, e_phi;
                logic e_irq;
                int idx;
                idx = g * 16 + o;
                c = 16'((g << 13) | (o << 9) | ((idx * 37) & 8'hFF));
                if (idx % 2 == 1) c = c | 16'h8000;
                if ((idx & 2) != 0) c = c | 16'h0100;
                do_reset();
                wr(3'd0, c);
                wr(3'd1, 16'(16'h1234 ^ idx));
                wr(3'd2, 16'hA5A5);
                wr(3'd3, 16'h5A5A);
                wr(3'd4, 16'h0000);
                if (g != 0) begin
                    e_cmd = 16'(((c & 16'h7E00) + 16'h0400) | 16'h00FF);
                    e_off = 16'h0000; e_plo = 16'hFFFF; e_phi = 16'hFFFF; e_irq = 1'b1;
                end else if (o == 15) begin
                    e_cmd = 16'h8600; e_off = 16'h0000; e_plo = 16'h0000; e_phi = 16'h0C00; e_irq = 1'b1;
                end else begin
                    e_cmd = c; e_off = 16'(16'h1234 ^ idx); e_plo = 16'hA5A5; e_phi = 16'h5A5A; e_irq = 1'b0;
                end
                rd(3'd0, v); check(g != 0 ? "R6 command" : (o == 15 ? "R7 command" : "R8 command"), v, e_cmd);
                rd(3'd1, v); check(g != 0 ? "R6 offset" : (o == 15 ? "R7 offset" : "R8 offset"), v, e_off);
                rd(3'd2, v); check(g != 0 ? "R6 param-low" : (o == 15 ? "R7 param-low" : "R8 param-low"), v, e_plo);
                rd(3'd3, v); check(g != 0 ? "R6 param-high" : (o == 15 ? "R7 param-high" : "R8 param-high"), v, e_phi);
                irq_is(g != 0 ? "R6 irq" : (o == 15 ? "R7 irq" : "R8 irq"), e_irq);
            end
        end

        // R7 / R9: startup arms the poll timer
        do_reset();
        wr(3'd0, 16'h1E00);
        wr(3'd4, 16'h0000);
        begin
            int s_edge;
            s_edge = last_edge;
            irq_is("R7 startup irq", 1'b1);
            wr(3'd4, 16'h0101);
            irq_is("R4 ack after startup", 1'b0);
            // re-trigger the rewritten command (group 0, opcode 3): ignored
            wr(3'd4, 16'h0000);
            irq_is("R8 startup image ignored", 1'b0);
            rd(3'd0, v); check("R8 startup image kept", v, 16'h8600);
            wait_edge(s_edge + PERIOD - 1);
            irq_is("R9 before first expiry", 1'b0);
            wait_edge(s_edge + PERIOD);
            irq_is("R9 first expiry raises", 1'b1);
            wait_edge(s_edge + 2 * PERIOD + 2);
            irq_is("R9 expiry while pending", 1'b1);
            wr(3'd4, 16'h0101);
            irq_is("R4 ack clears poll irq", 1'b0);
            wait_edge(s_edge + 3 * PERIOD - 1);
            irq_is("R9 before third expiry", 1'b0);
            wait_edge(s_edge + 3 * PERIOD);
            irq_is("R9 third expiry raises", 1'b1);
        end

        // R1: reset disarms the timer
        do_reset();
        begin
            int r_edge;
            r_edge = ccount;
            wait_edge(r_edge + 2 * PERIOD + 1);
            irq_is("R1 timer disarmed by reset", 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule